// File: doc/BRIEF.md
# Frame Timing and Vertical-Blank Controller

This block sequences the raster of a tile-based picture processor. A dot counter and a scanline counter step through a fixed frame of 262 lines of 341 dots. At the frame boundary the block raises the vertical-blank status flag and a CPU interrupt request. A status-register read strobe clears both of them. The scanline counter is numbered in frame order: lines 0 to 19 are vertical blank, line 20 is the pre-render line, lines 21 to 260 are rendered, and line 261 is the idle line that precedes the wrap.

The block also owns the working video-memory address. The CPU can write it directly at any time. On the pre-render line it is reloaded from the temporary address, but only while at least one of the two render-enable bits is set. When both bits are clear, the frame logic leaves the address alone. A backdrop palette-index output then follows the working address whenever that address lies in the palette page, so software can paint the screen one colour without rendering.

Top module: `frame_timing_ctrl`

## Requirements
- R1: While reset is asserted the outputs show line 261, dot 0, vblank 0, nmi_req 0, vaddr 0 and backdrop_idx 0. After release the counters start from that position.
- R2: The dot counter runs 0 to 340 and then wraps to 0 while the line advances by one. Line 261 wraps to line 0, so every frame is exactly 262 x 341 cycles.
- R3: vblank becomes 1 in the cycle whose position is line 0, dot 0. If nmi_en is high, nmi_req rises in that same cycle.
- R4: A one-cycle stat_rd clears vblank and nmi_req for the next cycle. Both are also cleared in the cycle whose position is line 20, dot 0.
- R5: If stat_rd is high in the cycle showing line 261, dot 340, vblank stays 0 for that frame, but nmi_req is still raised when nmi_en is high.
- R6: When nmi_en is low, nmi_req is 0 from the next cycle on and is not raised at the frame boundary. vblank is unaffected.
- R7: render_on is 1 when bg_en or spr_en is 1, and 0 only when both are 0.
- R8: While render_on is 1, vaddr takes the value of tmp_addr on the edge that leaves line 20, dot 304. The new value is seen at dot 305.
- R9: While render_on is 0, vaddr changes only through CPU writes. The pre-render reload does not happen.
- R10: backdrop_idx equals vaddr[4:0] when render_on is 0 and vaddr[13:8] is 0x3F, which covers all of 0x3F00 to 0x3FFF. In every other case it is 0.
- R11: cpu_we loads cpu_wdata into vaddr on the next edge, and it takes priority over a reload on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bg_en | input | 1 | Background render enable |
| spr_en | input | 1 | Sprite render enable |
| nmi_en | input | 1 | Allows the interrupt request |
| stat_rd | input | 1 | One-cycle strobe: status register read |
| tmp_addr | input | 14 | Temporary address, the reload source |
| cpu_we | input | 1 | CPU write strobe for the working address |
| cpu_wdata | input | 14 | CPU write data for the working address |
| line | output | 9 | Current scanline |
| dot | output | 9 | Current dot within the line |
| render_on | output | 1 | Either render enable is set |
| vblank | output | 1 | Vertical-blank status flag |
| nmi_req | output | 1 | Interrupt request to the CPU |
| vaddr | output | 14 | Working video-memory address |
| backdrop_idx | output | 5 | Palette index used for the backdrop |

## Verification
The hardest case to reach is the status read that lands in the very cycle the flag would rise. The read has to arrive on one exact edge out of nearly ninety thousand. The bench reaches it by watching the line and dot outputs until they show the last dot of the idle line, and asserting the strobe for exactly that one cycle. Reset starts the raster at the idle line, so three frame boundaries fit within the run: one normal, one colliding and one with the interrupt disabled. The reload and no-reload cases share these frames with them.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  typedef enum logic [1:0] {
    PH_VBLANK    = 2'd0,
    PH_PRERENDER = 2'd1,
    PH_VISIBLE   = 2'd2,
    PH_IDLE      = 2'd3
  } line_phase_e;
endpackage

// File: rtl/ftc_raster.sv
module ftc_raster
  import ftc_pkg::*;
#(
  parameter int DOTS = 341,
  parameter int VBL  = 20,
  parameter int VIS  = 240,
  parameter int LW   = 9,
  parameter int DW   = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [LW-1:0] line_o,
  output logic [DW-1:0] dot_o,
  output line_phase_e   phase_o,
  output logic          frame_end_o,
  output logic          pre_start_o
);
  localparam int LINES = VBL + 1 + VIS + 1;
  localparam logic [LW-1:0] PRE_L   = LW'(VBL);
  localparam logic [LW-1:0] IDLE_L  = LW'(LINES - 1);
  localparam logic [LW-1:0] LASTV_L = LW'(VBL - 1);
  localparam logic [DW-1:0] LASTD_L = DW'(DOTS - 1);

  logic [LW-1:0] line_q, line_d;
  logic [DW-1:0] dot_q, dot_d;
  logic          eol;

  always_comb begin
    eol    = (dot_q == LASTD_L);
    dot_d  = eol ? '0 : dot_q + 1'b1;
    line_d = line_q;
    if (eol) line_d = (line_q == IDLE_L) ? '0 : line_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= IDLE_L;
      dot_q  <= '0;
    end else begin
      line_q <= line_d;
      dot_q  <= dot_d;
    end
  end

  always_comb begin
    if (line_q < PRE_L)        phase_o = PH_VBLANK;
    else if (line_q == PRE_L)  phase_o = PH_PRERENDER;
    else if (line_q == IDLE_L) phase_o = PH_IDLE;
    else                       phase_o = PH_VISIBLE;
  end

  assign frame_end_o = (phase_o == PH_IDLE) && eol;
  assign pre_start_o = (line_q == LASTV_L) && eol;
  assign line_o      = line_q;
  assign dot_o       = dot_q;

  assert_dot_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dot_q <= LASTD_L);
  assert_line_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_q <= IDLE_L);
  assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_o |=> (line_q == '0) && (dot_q == '0));
endmodule

// File: rtl/ftc_vblank.sv
module ftc_vblank (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_end,
  input  logic pre_start,
  input  logic stat_rd,
  input  logic nmi_en,
  output logic vblank,
  output logic nmi_req
);
  logic flag_q, flag_d;
  logic nmi_q, nmi_d;

  always_comb begin
    flag_d = flag_q;
    if (frame_end)                 flag_d = !stat_rd;
    else if (stat_rd || pre_start) flag_d = 1'b0;

    nmi_d = nmi_q;
    if (!nmi_en)                   nmi_d = 1'b0;
    else if (frame_end)            nmi_d = 1'b1;
    else if (stat_rd || pre_start) nmi_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      nmi_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      nmi_q  <= nmi_d;
    end
  end

  assign vblank  = flag_q;
  assign nmi_req = nmi_q;

  assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !stat_rd) |=> vblank);
  assert_flag_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vblank) |-> $past(frame_end));
  assert_nmi_with_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && nmi_en) |=> nmi_req);
  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !frame_end) |=> (!vblank && !nmi_req));
  assert_prerender_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pre_start |=> !vblank);
  assert_collision_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && stat_rd) |=> !vblank);
  assert_nmi_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_en |=> !nmi_req);
endmodule

// File: rtl/ftc_vaddr.sv
module ftc_vaddr
  import ftc_pkg::*;
#(
  parameter int AW         = 14,
  parameter int DW         = 9,
  parameter int IDXW       = 5,
  parameter int RELOAD_DOT = 304,
  parameter int PAL_BASE   = 'h3F00
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            render_on,
  input  line_phase_e     phase,
  input  logic [DW-1:0]   dot,
  input  logic [AW-1:0]   tmp_addr,
  input  logic            cpu_we,
  input  logic [AW-1:0]   cpu_wdata,
  output logic [AW-1:0]   vaddr,
  output logic [IDXW-1:0] backdrop_idx
);
  localparam logic [AW-1:0] PB_L     = AW'(PAL_BASE);
  localparam logic [DW-1:0] RELOAD_L = DW'(RELOAD_DOT);

  logic [AW-1:0] va_q, va_d;
  logic          reload;
  logic          in_pal;

  always_comb begin
    reload = render_on && (phase == PH_PRERENDER) && (dot == RELOAD_L);
    va_d   = va_q;
    if (cpu_we)      va_d = cpu_wdata;
    else if (reload) va_d = tmp_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) va_q <= '0;
    else        va_q <= va_d;
  end

  always_comb begin
    in_pal       = (va_q[AW-1:8] == PB_L[AW-1:8]);
    backdrop_idx = (!render_on && in_pal) ? va_q[IDXW-1:0] : '0;
  end

  assign vaddr = va_q;

  assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (render_on && phase == PH_PRERENDER && dot == RELOAD_L && !cpu_we)
      |=> (vaddr == $past(tmp_addr)));
  assert_hold_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!render_on && !cpu_we) |=> $stable(vaddr));
  assert_cpu_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_we |=> (vaddr == $past(cpu_wdata)));
  always_comb begin
    if (rst_n && render_on)
      assert_backdrop_on_R10: assert (backdrop_idx == '0);
  end
endmodule

// File: rtl/frame_timing_ctrl.sv
module frame_timing_ctrl
  import ftc_pkg::*;
#(
  parameter int DOTS       = 341,
  parameter int VBL        = 20,
  parameter int VIS        = 240,
  parameter int RELOAD_DOT = 304,
  parameter int AW         = 14,
  parameter int IDXW       = 5,
  parameter int PAL_BASE   = 'h3F00,
  localparam int LW = $clog2(VBL + VIS + 2),
  localparam int DW = $clog2(DOTS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bg_en,
  input  logic            spr_en,
  input  logic            nmi_en,
  input  logic            stat_rd,
  input  logic [AW-1:0]   tmp_addr,
  input  logic            cpu_we,
  input  logic [AW-1:0]   cpu_wdata,
  output logic [LW-1:0]   line,
  output logic [DW-1:0]   dot,
  output logic            render_on,
  output logic            vblank,
  output logic            nmi_req,
  output logic [AW-1:0]   vaddr,
  output logic [IDXW-1:0] backdrop_idx
);
  logic [1:0]  rst_sync_q;
  logic        rst_n_s;
  line_phase_e phase;
  logic        frame_end;
  logic        pre_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign render_on = bg_en | spr_en;

  ftc_raster #(.DOTS(DOTS), .VBL(VBL), .VIS(VIS), .LW(LW), .DW(DW)) u_raster (
    .clk(clk), .rst_n(rst_n_s), .line_o(line), .dot_o(dot), .phase_o(phase),
    .frame_end_o(frame_end), .pre_start_o(pre_start)
  );

  ftc_vblank u_vblank (
    .clk(clk), .rst_n(rst_n_s), .frame_end(frame_end), .pre_start(pre_start),
    .stat_rd(stat_rd), .nmi_en(nmi_en), .vblank(vblank), .nmi_req(nmi_req)
  );

  ftc_vaddr #(.AW(AW), .DW(DW), .IDXW(IDXW), .RELOAD_DOT(RELOAD_DOT),
              .PAL_BASE(PAL_BASE)) u_vaddr (
    .clk(clk), .rst_n(rst_n_s), .render_on(render_on), .phase(phase), .dot(dot),
    .tmp_addr(tmp_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .vaddr(vaddr), .backdrop_idx(backdrop_idx)
  );

  always_comb begin
    assert_render_or_R7: assert (render_on == (bg_en || spr_en));
  end
endmodule

// File: tb/tb_frame_timing_ctrl.sv
module tb_frame_timing_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bg_en, spr_en, nmi_en, stat_rd, cpu_we;
  logic [13:0] tmp_addr, cpu_wdata;
  logic [8:0]  line, dot;
  logic        render_on, vblank, nmi_req;
  logic [13:0] vaddr;
  logic [4:0]  backdrop_idx;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  frame_timing_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bg_en(bg_en), .spr_en(spr_en), .nmi_en(nmi_en),
    .stat_rd(stat_rd), .tmp_addr(tmp_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .line(line), .dot(dot), .render_on(render_on), .vblank(vblank),
    .nmi_req(nmi_req), .vaddr(vaddr), .backdrop_idx(backdrop_idx)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_pos(input int l, input int d);
    forever begin
      @(negedge clk);
      if (line == 9'(l) && dot == 9'(d)) break;
    end
  endtask

  task automatic cpu_write(input logic [13:0] v);
    cpu_we = 1'b1; cpu_wdata = v;
    @(negedge clk);
    cpu_we = 1'b0;
    check(vaddr == v, "R11", "cpu write", vaddr, v);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(line == 9'd261 && dot == 9'd0, "R1", "reset position", {line, dot}, {9'd261, 9'd0});
    check(!vblank && !nmi_req, "R1", "reset flags", {vblank, nmi_req}, 0);
    check(vaddr == 14'd0 && backdrop_idx == 5'd0, "R1", "reset address", vaddr, 0);
    for (int k = 0; k < 4; k++) begin
      {bg_en, spr_en} = 2'(k);
      #1;
      check(render_on == (k != 0), "R7", "render_on", render_on, k != 0);
    end
    {bg_en, spr_en} = 2'b00;
  endtask

  task automatic t_counter;
    int el, ed, bad;
    bad = 0;
    wait_pos(261, 1);
    el = 261; ed = 1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (ed == 340) begin ed = 0; el = (el == 261) ? 0 : el + 1; end
      else ed++;
      if (line != 9'(el) || dot != 9'(ed)) bad++;
    end
    check(bad == 0, "R2", "raster mismatches", bad, 0);
  endtask

  task automatic t_vblank_set;
    cpu_write(14'h1234);
    tmp_addr = 14'h0ABC;
    spr_en = 1'b1;
    wait_pos(261, 340);
    check(!vblank, "R3", "flag before boundary", vblank, 0);
    @(negedge clk);
    check(line == 0 && dot == 0 && vblank && nmi_req, "R3", "flag and nmi at line 0",
          {line, dot, vblank, nmi_req}, 2'b11);
  endtask

  task automatic t_read_clear;
    wait_pos(0, 10);
    check(vblank && nmi_req, "R3", "flag held", {vblank, nmi_req}, 2'b11);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    check(!vblank && !nmi_req, "R4", "read clears", {vblank, nmi_req}, 0);
  endtask

  task automatic t_reload_on;
    wait_pos(20, 304);
    check(vaddr == 14'h1234, "R8", "before reload", vaddr, 14'h1234);
    @(negedge clk);
    check(vaddr == 14'h0ABC, "R8", "reload with sprites only", vaddr, 14'h0ABC);
  endtask

  task automatic t_backdrop;
    wait_pos(30, 0);
    cpu_write(14'h3F07);
    check(backdrop_idx == 5'd0, "R10", "render on backdrop", backdrop_idx, 0);
    spr_en = 1'b0;
    #1;
    check(backdrop_idx == 5'h07, "R10", "palette backdrop", backdrop_idx, 5'h07);
    cpu_write(14'h3000);
    check(backdrop_idx == 5'd0, "R10", "outside palette", backdrop_idx, 0);
    cpu_write(14'h3FF5);
    check(backdrop_idx == 5'h15, "R10", "palette mirror", backdrop_idx, 5'h15);
  endtask

  task automatic t_collision;
    tmp_addr = 14'h0111;
    wait_pos(261, 340);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    check(!vblank, "R5", "flag suppressed", vblank, 0);
    check(nmi_req, "R5", "nmi still raised", nmi_req, 1);
    wait_pos(19, 340);
    check(nmi_req && !vblank, "R5", "state held", {vblank, nmi_req}, 2'b01);
    @(negedge clk);
    check(!nmi_req, "R4", "pre-render clears nmi", nmi_req, 0);
    wait_pos(20, 305);
    check(vaddr == 14'h3FF5, "R9", "no reload when off", vaddr, 14'h3FF5);
    check(backdrop_idx == 5'h15, "R10", "backdrop kept", backdrop_idx, 5'h15);
  endtask

  task automatic t_nmi_off;
    nmi_en = 1'b0;
    wait_pos(261, 340);
    @(negedge clk);
    check(vblank && !nmi_req, "R6", "flag without nmi", {vblank, nmi_req}, 2'b10);
    wait_pos(19, 340);
    check(vblank, "R4", "flag held to pre-render", vblank, 1);
    @(negedge clk);
    check(!vblank, "R4", "pre-render clears flag", vblank, 0);
  endtask

  task automatic t_priority;
    bg_en = 1'b1;
    tmp_addr = 14'h0555;
    wait_pos(20, 304);
    cpu_we = 1'b1; cpu_wdata = 14'h2222;
    @(negedge clk);
    cpu_we = 1'b0;
    check(vaddr == 14'h2222, "R11", "write beats reload", vaddr, 14'h2222);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bg_en = 1'b0; spr_en = 1'b0; nmi_en = 1'b1; stat_rd = 1'b0;
    tmp_addr = '0; cpu_we = 1'b0; cpu_wdata = '0;
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    t_counter;
    t_vblank_set;
    t_read_clear;
    t_reload_on;
    t_backdrop;
    t_collision;
    t_nmi_off;
    t_priority;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule